// File: doc/BRIEF.md
# Overflow-Driven Interval Timer

This block is a single-channel interval timer. Its counter runs upward and raises an event when it rolls over past its all-ones value. Software sets the interval from the far end: to get an event after N counting cycles it stores the all-ones value minus N, then starts the counter.

With the reload option enabled, each rollover copies a stored reload value back into the counter and the count carries on. That gives a fixed period, set by storing the all-ones value minus (period − 1). Without the option, the counter falls to zero at the rollover and halts.

A small word-addressed register bus drives the block. Reads are combinational and writes take effect on the clock edge. A control write does not act at once. It is held for a fixed number of timer-clock edges before it takes hold, which models the start latency of a real timer. The rollover sets a sticky status bit, which is cleared by writing one to it. An enable bit gates that status onto a level-high interrupt line.

Top module: `uptimer_top`

## Requirements
- R1: After reset, every readable register (control at address 0, reload at 1, count at 2, status at 3, interrupt enable at 4) reads zero and the interrupt output is low.
- R2: While running, the count rises by exactly one on every clock edge. Counting starts on the edge after the run bit takes hold.
- R3: A write to the control register (bit 0 run, bit 1 auto-reload, bit 2 copy-reload-now) takes hold on the third clock edge after the write edge (START_LAT = 3). Until then the count and the control readback keep their old values.
- R4: When a control write with bit 2 set takes hold, the counter is loaded with the reload register (address 1) on that same edge. Bit 2 always reads back as zero.
- R5: With the count at all-ones while running, the next edge is a rollover and sets status bit 0. A one-shot loaded with 0xFFFFFFFF − N therefore rolls over N+1 edges after run takes hold.
- R6: At a rollover with auto-reload clear, the counter becomes zero and the run bit clears.
- R7: At a rollover with auto-reload set, the counter takes the reload value and keeps running. With a reload of 0xFFFFFFFF − (P − 1), rollovers repeat every P edges.
- R8: Clearing the run bit stops counting. The count then holds its value.
- R9: Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. A rollover on the same edge as the clearing write wins, and the bit stays set.
- R10: The interrupt output is high exactly while status bit 0 and interrupt-enable bit 0 (address 4) are both set.
- R11: A write to the count register (address 2) replaces the count on the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Level-high rollover interrupt |

## Verification
Every check is tied to the edge number of the write that caused it. A register write lands on its own edge. A control write lands three edges later. Counting starts one edge after that, and a rollover appears one edge after all-ones is reached. The bench keeps a running edge counter and records the edge of each write. It waits to a computed edge, drives the read address there, and the monitor compares one nanosecond after the falling edge. That way every sample falls between edges, after the edge whose effect it checks.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LOAD  = 3'd1,
    A_COUNT = 3'd2,
    A_STAT  = 3'd3,
    A_IRQEN = 3'd4
  } reg_addr_e;

  localparam int BIT_RUN   = 0;
  localparam int BIT_AUTO  = 1;
  localparam int BIT_LDNOW = 2;

  typedef struct packed {
    logic load_now;
    logic autoreload;
    logic run;
  } ctrl_req_t;

endpackage

// File: rtl/uptimer_ctrl_sync.sv
module uptimer_ctrl_sync
  import uptimer_pkg::*;
#(
  parameter int START_LAT = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_stb,
  input  ctrl_req_t wr_req,
  output logic      apply,
  output ctrl_req_t apply_req
);

  logic      pend_q, pend_d;
  ctrl_req_t req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (wr_stb) req_d = wr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign apply_req = req_q;

  generate
    if (START_LAT <= 1) begin : g_direct
      always_comb begin
        pend_d = 1'b0;
        if (wr_stb) pend_d = 1'b1;
      end
      assign apply = pend_q;
    end else begin : g_delay
      localparam int LAT_W = $clog2(START_LAT);
      localparam logic [LAT_W-1:0] LAT_INIT = LAT_W'(START_LAT - 1);
      logic [LAT_W-1:0] lat_q, lat_d;

      always_comb begin
        pend_d = pend_q;
        lat_d  = lat_q;
        if (wr_stb) begin
          pend_d = 1'b1;
          lat_d  = LAT_INIT;
        end else if (pend_q) begin
          if (lat_q == '0) pend_d = 1'b0;
          else             lat_d  = lat_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
      end

      assign apply = pend_q && (lat_q == '0);

      AST_CTRL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !apply); // R3
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/uptimer_core.sv
module uptimer_core
  import uptimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  ctrl_req_t        apply_req,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             autoreload,
  output logic             ovf_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             auto_q, auto_d;

  assign ovf_evt = run_q && (&cnt_q);

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    auto_d = auto_q;
    if (cnt_wr) begin
      cnt_d = cnt_wdata;
    end else if (apply && apply_req.load_now) begin
      cnt_d = load_val;
    end else if (ovf_evt) begin
      cnt_d = auto_q ? load_val : '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (apply) begin
      run_d  = apply_req.run;
      auto_d = apply_req.autoreload;
    end else if (ovf_evt && !auto_q) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      auto_q <= auto_d;
    end
  end

  assign cnt        = cnt_q;
  assign run        = run_q;
  assign autoreload = auto_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !ovf_evt && !cnt_wr && !apply |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_WRAP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !auto_q && !cnt_wr && !apply |=> (cnt_q == '0) && !run_q); // R6
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && auto_q && !cnt_wr && !apply |=> (cnt_q == $past(load_val)) && run_q); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !cnt_wr && !apply |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/uptimer_regs.sv
module uptimer_regs
  import uptimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             ovf_evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             autoreload,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq,
  output logic [CNT_W-1:0] load_val,
  output logic             ctrl_wr,
  output ctrl_req_t        ctrl_req,
  output logic             cnt_wr
);

  logic             wr_en;
  logic             load_wr, stat_wr, ien_wr;
  logic [CNT_W-1:0] load_q, load_d;
  logic             stat_q, stat_d;
  logic             ien_q, ien_d;

  assign wr_en   = bus_sel && bus_we;
  assign ctrl_wr = wr_en && (bus_addr == A_CTRL);
  assign load_wr = wr_en && (bus_addr == A_LOAD);
  assign cnt_wr  = wr_en && (bus_addr == A_COUNT);
  assign stat_wr = wr_en && (bus_addr == A_STAT);
  assign ien_wr  = wr_en && (bus_addr == A_IRQEN);

  assign ctrl_req.run        = bus_wdata[BIT_RUN];
  assign ctrl_req.autoreload = bus_wdata[BIT_AUTO];
  assign ctrl_req.load_now   = bus_wdata[BIT_LDNOW];

  always_comb begin
    load_d = load_wr ? bus_wdata : load_q;
    ien_d  = ien_wr ? bus_wdata[0] : ien_q;
    stat_d = ovf_evt | (stat_q & ~(stat_wr & bus_wdata[0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      stat_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      load_q <= load_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[BIT_RUN]  = run;
        bus_rdata[BIT_AUTO] = autoreload;
      end
      A_LOAD:  bus_rdata    = load_q;
      A_COUNT: bus_rdata    = cnt;
      A_STAT:  bus_rdata[0] = stat_q;
      A_IRQEN: bus_rdata[0] = ien_q;
      default: bus_rdata    = '0;
    endcase
  end

  assign load_val = load_q;
  assign irq      = stat_q & ien_q;

  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_q); // R5
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && bus_wdata[0] && !ovf_evt |=> !stat_q); // R9
  AST_STAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !(stat_wr && bus_wdata[0]) |=> stat_q); // R9

endmodule

// File: rtl/uptimer_top.sv
module uptimer_top
  import uptimer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int START_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);

  logic             ctrl_wr, cnt_wr, apply, ovf_evt, run, autoreload;
  ctrl_req_t        ctrl_req, apply_req;
  logic [CNT_W-1:0] load_val, cnt;

  uptimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ovf_evt(ovf_evt), .cnt(cnt), .run(run), .autoreload(autoreload),
    .bus_rdata(bus_rdata), .irq(irq), .load_val(load_val),
    .ctrl_wr(ctrl_wr), .ctrl_req(ctrl_req), .cnt_wr(cnt_wr)
  );

  uptimer_ctrl_sync #(.START_LAT(START_LAT)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(ctrl_wr), .wr_req(ctrl_req),
    .apply(apply), .apply_req(apply_req)
  );

  uptimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .apply(apply), .apply_req(apply_req), .load_val(load_val),
    .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata),
    .cnt(cnt), .run(run), .autoreload(autoreload), .ovf_evt(ovf_evt)
  );

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ovf_evt) || $past(bus_sel && bus_we && bus_addr == A_IRQEN)); // R10

endmodule

// File: tb/uptimer_top_bench.sv
`timescale 1ns/1ps
module uptimer_top_bench;
  import uptimer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_w = 0;
  bit finished = 0;

  bit          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uptimer_top u_uptimer_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compares one item per falling edge, between clock edges
  bit          m_kind;
  logic [31:0] m_exp, m_act;
  string       m_tag;
  always @(negedge clk) begin
    #1;
    if (q_kind.size() > 0) begin
      m_kind = q_kind.pop_front();
      m_exp  = q_exp.pop_front();
      m_tag  = q_tag.pop_front();
      m_act  = m_kind ? {31'd0, irq} : bus_rdata;
      total++;
      if (m_act !== m_exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", m_tag, m_act, m_exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    last_w = cyc + 1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    q_kind.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    q_kind.push_back(1'b1); q_exp.push_back({31'd0, e}); q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w;
    int w2;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(A_CTRL,  32'h0, "R1 ctrl");
    chk(A_LOAD,  32'h0, "R1 load");
    chk(A_COUNT, 32'h0, "R1 count");
    chk(A_STAT,  32'h0, "R1 stat");
    chk(A_IRQEN, 32'h0, "R1 irqen");
    chk_irq(1'b0, "R1 irq");

    wr(A_COUNT, 32'h1234);
    chk(A_COUNT, 32'h1234, "R11 direct count write");

    wr(A_LOAD, 32'h100);
    wr(A_CTRL, 32'h5);
    w = last_w;
    chk(A_COUNT, 32'h1234, "R3 no effect at +0");
    chk(A_COUNT, 32'h1234, "R3 no effect at +1");
    chk(A_COUNT, 32'h1234, "R3 no effect at +2");
    chk(A_COUNT, 32'h100,  "R4 reload copied at +3");
    chk(A_COUNT, 32'h101,  "R2 first increment");
    chk(A_CTRL,  32'h1,    "R3 run visible, R4 bit2 reads zero");
    wait_to(w + 9);
    chk(A_COUNT, 32'h106,  "R2 steady counting");

    wr(A_CTRL, 32'h0);
    w2 = last_w;
    wait_to(w2 + 5);
    chk(A_COUNT, 32'h100 + 32'(w2 - w), "R8 held after stop");
    chk(A_COUNT, 32'h100 + 32'(w2 - w), "R8 still held");

    wr(A_COUNT, 32'hFFFF_FFFA);
    wr(A_IRQEN, 32'h1);
    chk_irq(1'b0, "R10 enable alone");
    wr(A_CTRL, 32'h1);
    w = last_w;
    wait_to(w + 7);
    chk(A_STAT,  32'h0,         "R5 no early rollover");
    chk(A_COUNT, 32'hFFFF_FFFF, "R5 reaches all-ones");
    chk(A_STAT,  32'h1,         "R5 rollover sets status");
    chk(A_COUNT, 32'h0,         "R6 wraps to zero");
    chk(A_CTRL,  32'h0,         "R6 run cleared");
    chk_irq(1'b1, "R10 irq high");

    wr(A_IRQEN, 32'h0);
    chk_irq(1'b0, "R10 masked");
    chk(A_STAT, 32'h1, "R10 status kept while masked");
    wr(A_IRQEN, 32'h1);
    chk_irq(1'b1, "R10 unmasked");

    wr(A_STAT, 32'h0);
    chk(A_STAT, 32'h1, "R9 zero write ignored");
    wr(A_STAT, 32'h1);
    chk(A_STAT, 32'h0, "R9 cleared");
    chk_irq(1'b0, "R10 low after clear");

    wr(A_LOAD, 32'hFFFF_FFFC);
    wr(A_CTRL, 32'h7);
    w = last_w;
    wait_to(w + 3);
    chk(A_COUNT, 32'hFFFF_FFFC, "R4 periodic start value");
    wait_to(w + 6);
    chk(A_COUNT, 32'hFFFF_FFFF, "R7 all-ones before rollover");
    chk(A_STAT,  32'h1,         "R7 first rollover");
    chk(A_COUNT, 32'hFFFF_FFFD, "R7 reloaded and running");
    wr(A_STAT, 32'h1);
    chk(A_STAT,  32'h0, "R9 clear in periodic");
    chk(A_STAT,  32'h1, "R7 second rollover after 4 edges");
    chk(A_CTRL,  32'h3, "R7 still running");
    wait_to(w + 14);
    wr(A_STAT, 32'h1);
    chk(A_STAT,  32'h1, "R9 rollover beats clear");

    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule